// File: doc/BRIEF.md
# Windowed Vertical Field Divider

The block counts half-line clock pulses (two per line period) and decides on which pulse the vertical field restarts. A restart follows a separated vertical sync edge when that edge falls inside an acceptance window, or is forced when the window runs out. The width of the window depends on the current mode. A saturating confidence counter, scored on every restart, moves the divider between a wide search window, a narrow window locked to the 60 Hz or 50 Hz norm, and a fixed standard-ratio mode. Once the field timing is trusted, the standard-ratio mode holds it steady against damaged or copy-guarded sync.

The outputs are a one-clock field restart pulse, the current mode, a 50/60 Hz identification flag and a gating pulse that blanks the line phase detector around vertical sync. A no-transmitter flag forces a fixed field length in search mode, which gives a stable picture on noise. A force input holds the divider in search mode.

Top module: `vfield_divider`

## Requirements
- R1: The count is 1 in the first clock after a restart and rises by 1 per clock. `field_rst_o` is high for exactly the one clock in which the count is 1. In search mode, a rising edge of `vsync_i` seen at count c with 488 <= c <= 722 restarts the field, giving a field of c clocks. Edges outside that range are ignored.
- R2: In search mode, with no accepted edge and no forced restart, the field restarts at count 722.
- R3: A confidence value of 0..15 is cleared by reset and saturates at both ends. In search mode, an accepted edge at a count in 522..528 or 622..628 adds 1. An accepted edge elsewhere subtracts 1, and so does any restart without an accepted edge.
- R4: Every accepted search edge sets the norm flag `id_50_o` to 1 if its count is above 576 and to 0 otherwise. A search restart that leaves the confidence at 12 or more switches to narrow mode.
- R5: In narrow mode the window is 622..628 when `id_50_o` = 1 and 522..528 otherwise. Edges outside the window are ignored. With no edge in the window, the field restarts at the window's last count and the confidence drops by 1. At 0 the divider returns to search mode.
- R6: In narrow mode, an edge in the window raises the confidence while it is below 12. From 12 on, only an edge exactly at the standard count (625 when `id_50_o` = 1, 525 otherwise) raises it, and other edges in the window leave it unchanged. Reaching 14 enters standard mode.
- R7: In standard mode the field always restarts at the standard count. An edge exactly at that count adds 1, and its absence subtracts 1. Falling to 10 or below returns the divider to search mode.
- R8: In search mode, while `no_tx_i` is high, the field restarts at count 628 unless a `vsync_i` edge has been seen earlier in the same field. Such a restart scores as a miss.
- R9: While `force_search_i` is high, the clock is handled as in search mode. `mode_o` is search on the following clock and the confidence is cleared.
- R10: `gate_o` goes high in the clock in which `field_rst_o` is high with search mode shown, and stays high for 18 clocks. In narrow or standard mode it goes high at the standard count minus 6 and stays high for 24 clocks. A new start reloads the length.
- R11: While reset is active: `mode_o` = 0 (search), `field_rst_o` = 0, `id_50_o` = 0, `gate_o` = 0. The encoding of `mode_o` is 0 = search, 1 = narrow, 2 = standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-line clock, two pulses per line |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Separated vertical sync; the rising edge is used |
| no_tx_i | input | 1 | No transmitter detected |
| force_search_i | input | 1 | Hold the divider in search mode |
| field_rst_o | output | 1 | One-clock field restart pulse |
| mode_o | output | 2 | 0 search, 1 narrow, 2 standard |
| id_50_o | output | 1 | 1 = 50 Hz norm, 0 = 60 Hz norm |
| gate_o | output | 1 | Phase detector inhibit pulse |

## Verification
The confidence value cannot be seen from outside. A wrong value therefore shows up only as a mode change on the wrong restart. For that reason every lock, promotion and fall-back is driven with a known number of fields, and the mode is checked both on the restart before the expected change and on the restart of the change itself. A wrong count or window shows up at once, in the first field, as a change in the spacing of `field_rst_o`. A wrong norm flag moves the locked window and the gate start by about 100 clocks within one field.

// File: rtl/vfd_pkg.sv
`timescale 1ns/1ps
package vfd_pkg;
  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_STD    = 2'd2
  } vfd_mode_e;

  typedef enum logic [1:0] {
    CONF_HOLD = 2'd0,
    CONF_INC  = 2'd1,
    CONF_DEC  = 2'd2,
    CONF_CLR  = 2'd3
  } conf_op_e;
endpackage

// File: rtl/vfd_sync_edge.sv
`timescale 1ns/1ps
module vfd_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic restart_i,
  output logic evt_o,
  output logic seen_o
);
  logic vs_q, seen_q;

  assign evt_o  = vsync_i & ~vs_q;
  assign seen_o = seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      vs_q   <= vsync_i;
      seen_q <= restart_i ? 1'b0 : (seen_q | evt_o);
    end
  end

  AST_SEEN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !restart_i) |=> seen_o); // R8
endmodule

// File: rtl/vfd_conf.sv
`timescale 1ns/1ps
module vfd_conf
  import vfd_pkg::*;
#(
  parameter int KW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  conf_op_e      op_i,
  output logic [KW-1:0] conf_o,
  output logic [KW-1:0] conf_nxt_o
);
  localparam logic [KW-1:0] KMAX = '1;

  always_comb begin
    conf_nxt_o = conf_o;
    unique case (op_i)
      CONF_INC: if (conf_o != KMAX) conf_nxt_o = conf_o + 1'b1;
      CONF_DEC: if (conf_o != '0)   conf_nxt_o = conf_o - 1'b1;
      CONF_CLR: conf_nxt_o = '0;
      default:  conf_nxt_o = conf_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conf_o <= '0;
    else         conf_o <= conf_nxt_o;
  end

  AST_CONF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(op_i) != CONF_CLR) |->
      (int'(conf_o) - int'($past(conf_o)) <= 1 &&
       int'($past(conf_o)) - int'(conf_o) <= 1)); // R3
endmodule

// File: rtl/vfd_gate.sv
`timescale 1ns/1ps
module vfd_gate #(
  parameter int LEN_SRCH = 18,
  parameter int LEN_LOCK = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_srch_i,
  input  logic start_lock_i,
  output logic gate_o
);
  localparam int LEN_MAX = (LEN_SRCH > LEN_LOCK) ? LEN_SRCH : LEN_LOCK;
  localparam int GW      = $clog2(LEN_MAX + 1);

  logic [GW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rem_q <= '0;
    else if (start_srch_i) rem_q <= GW'(LEN_SRCH - 1);
    else if (start_lock_i) rem_q <= GW'(LEN_LOCK - 1);
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign gate_o = start_srch_i | start_lock_i | (rem_q != '0);
endmodule

// File: rtl/vfield_divider.sv
`timescale 1ns/1ps
module vfield_divider
  import vfd_pkg::*;
#(
  parameter int SRCH_LO   = 488,
  parameter int SRCH_HI   = 722,
  parameter int N60_LO    = 522,
  parameter int N60_HI    = 528,
  parameter int N50_LO    = 622,
  parameter int N50_HI    = 628,
  parameter int STD60     = 525,
  parameter int STD50     = 625,
  parameter int NOTX_CNT  = 628,
  parameter int SPLIT     = 576,
  parameter int CONF_W    = 4,
  parameter int CONF_LOCK = 12,
  parameter int CONF_STD  = 14,
  parameter int CONF_DROP = 10,
  parameter int EQ_LEAD   = 6,
  parameter int GATE_SRCH = 18,
  parameter int GATE_LOCK = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vsync_i,
  input  logic       no_tx_i,
  input  logic       force_search_i,
  output logic       field_rst_o,
  output logic [1:0] mode_o,
  output logic       id_50_o,
  output logic       gate_o
);
  localparam int CW = $clog2(SRCH_HI + 1);
  localparam logic [CW-1:0] C_SLO   = CW'(SRCH_LO);
  localparam logic [CW-1:0] C_SHI   = CW'(SRCH_HI);
  localparam logic [CW-1:0] C_NOTX  = CW'(NOTX_CNT);
  localparam logic [CW-1:0] C_SPLIT = CW'(SPLIT);
  localparam logic [CW-1:0] C_ONE   = CW'(1);
  localparam logic [CONF_W-1:0] K_LOCK = CONF_W'(CONF_LOCK);
  localparam logic [CONF_W-1:0] K_STD  = CONF_W'(CONF_STD);
  localparam logic [CONF_W-1:0] K_DROP = CONF_W'(CONF_DROP);

  logic [CW-1:0]     cnt_q, cnt_d;
  vfd_mode_e         mode_q, mode_d, mode_eff;
  logic              norm50_q, norm50_d;
  logic              frst_q, restart;
  conf_op_e          op;
  logic [CONF_W-1:0] conf_q, conf_nxt;
  logic              evt, seen;
  logic [CW-1:0]     nar_lo, nar_hi, std_cnt, eq_cnt;
  logic              in_srch, in_nar_any, in_nar;

  vfd_sync_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vsync_i   (vsync_i),
    .restart_i (restart),
    .evt_o     (evt),
    .seen_o    (seen)
  );

  vfd_conf #(.KW(CONF_W)) u_conf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .conf_o     (conf_q),
    .conf_nxt_o (conf_nxt)
  );

  vfd_gate #(.LEN_SRCH(GATE_SRCH), .LEN_LOCK(GATE_LOCK)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_srch_i (frst_q && mode_q == MODE_SEARCH),
    .start_lock_i (mode_q != MODE_SEARCH && cnt_q == eq_cnt),
    .gate_o       (gate_o)
  );

  // window limits for the current norm
  assign nar_lo  = norm50_q ? CW'(N50_LO) : CW'(N60_LO);
  assign nar_hi  = norm50_q ? CW'(N50_HI) : CW'(N60_HI);
  assign std_cnt = norm50_q ? CW'(STD50)  : CW'(STD60);
  assign eq_cnt  = std_cnt - CW'(EQ_LEAD);

  assign in_srch    = cnt_q >= C_SLO && cnt_q <= C_SHI;
  assign in_nar_any = (cnt_q >= CW'(N60_LO) && cnt_q <= CW'(N60_HI)) ||
                      (cnt_q >= CW'(N50_LO) && cnt_q <= CW'(N50_HI));
  assign in_nar     = cnt_q >= nar_lo && cnt_q <= nar_hi;

  assign mode_eff = force_search_i ? MODE_SEARCH : mode_q;

  // restart decision and confidence scoring
  always_comb begin
    restart  = 1'b0;
    op       = CONF_HOLD;
    norm50_d = norm50_q;
    unique case (mode_eff)
      MODE_SEARCH: begin
        if (evt && in_srch) begin
          restart  = 1'b1;
          norm50_d = cnt_q > C_SPLIT;
          op       = in_nar_any ? CONF_INC : CONF_DEC;
        end else if (no_tx_i && !seen && cnt_q == C_NOTX) begin
          restart = 1'b1;
          op      = CONF_DEC;
        end else if (cnt_q >= C_SHI) begin
          restart = 1'b1;
          op      = CONF_DEC;
        end
      end
      MODE_NARROW: begin
        if (evt && in_nar) begin
          restart = 1'b1;
          if (conf_q < K_LOCK || cnt_q == std_cnt) op = CONF_INC;
        end else if (cnt_q >= nar_hi) begin
          restart = 1'b1;
          op      = CONF_DEC;
        end
      end
      MODE_STD: begin
        if (cnt_q >= std_cnt) begin
          restart = 1'b1;
          op      = evt ? CONF_INC : CONF_DEC;
        end
      end
      default: restart = 1'b1;
    endcase
    if (force_search_i) op = CONF_CLR;
  end

  // mode transitions, evaluated on restart
  always_comb begin
    mode_d = mode_eff;
    if (restart && !force_search_i) begin
      unique case (mode_eff)
        MODE_SEARCH: if (conf_nxt >= K_LOCK) mode_d = MODE_NARROW;
        MODE_NARROW: begin
          if (conf_nxt >= K_STD)     mode_d = MODE_STD;
          else if (conf_nxt == '0)   mode_d = MODE_SEARCH;
        end
        MODE_STD:    if (conf_nxt <= K_DROP) mode_d = MODE_SEARCH;
        default:     mode_d = MODE_SEARCH;
      endcase
    end
  end

  assign cnt_d = restart ? C_ONE : cnt_q + C_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= C_ONE;
      mode_q   <= MODE_SEARCH;
      norm50_q <= 1'b0;
      frst_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      norm50_q <= norm50_d;
      frst_q   <= restart;
    end
  end

  assign field_rst_o = frst_q;
  assign mode_o      = mode_q;
  assign id_50_o     = norm50_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= C_ONE && cnt_q <= C_SHI); // R2
  AST_RST_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_rst_o |-> cnt_q == C_ONE); // R1
  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NARROW && $past(mode_q) == MODE_SEARCH) |-> conf_q >= K_LOCK); // R4
  AST_STD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD && $past(mode_q) != MODE_STD) |-> conf_q >= K_STD); // R6
  AST_STD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD && !force_search_i && cnt_q == std_cnt) |=> field_rst_o); // R7
  AST_FORCE_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_search_i |=> (mode_q == MODE_SEARCH && conf_q == '0)); // R9
endmodule

// File: tb/vfield_divider_bench.sv
`timescale 1ns/1ps
module vfield_divider_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic notx = 1'b0;
  logic force_s = 1'b0;
  logic field_rst_o, id_50_o, gate_o;
  logic [1:0] mode_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int tgt = 0, tgt2 = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 1, m_mode = 0, m_conf = 0, m_n50 = 0, m_seen = 0;
  int m_vsq = 0, m_frst = 0, m_grem = 0;
  int c, ev, rs, em, nc, lo, hi, sd, nmode, nn50;

  always #2.5 clk = ~clk;

  vfield_divider u_vfield_divider (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .vsync_i        (vsync),
    .no_tx_i        (notx),
    .force_search_i (force_s),
    .field_rst_o    (field_rst_o),
    .mode_o         (mode_o),
    .id_50_o        (id_50_o),
    .gate_o         (gate_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_std();
    return (m_n50 != 0) ? 625 : 525;
  endfunction

  function automatic int m_gate();
    return ((m_frst != 0 && m_mode == 0) || (m_mode != 0 && m_cnt == m_std() - 6) ||
            m_grem != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) cyc++;

  // behavioural reference, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 1; m_mode = 0; m_conf = 0; m_n50 = 0; m_seen = 0;
      m_vsq = 0; m_frst = 0; m_grem = 0;
    end else begin
      c = m_cnt; ev = (vsync && m_vsq == 0) ? 1 : 0;
      em = force_s ? 0 : m_mode; rs = 0; nc = m_conf; nn50 = m_n50;
      lo = m_n50 ? 622 : 522; hi = m_n50 ? 628 : 528; sd = m_std();
      if (em == 0) begin
        if (ev != 0 && c >= 488 && c <= 722) begin
          rs = 1; nn50 = (c > 576) ? 1 : 0;
          if ((c >= 522 && c <= 528) || (c >= 622 && c <= 628)) nc++; else nc--;
        end else if (notx && m_seen == 0 && c == 628) begin rs = 1; nc--; end
        else if (c >= 722) begin rs = 1; nc--; end
      end else if (em == 1) begin
        if (ev != 0 && c >= lo && c <= hi) begin
          rs = 1; if (m_conf < 12 || c == sd) nc++;
        end else if (c >= hi) begin rs = 1; nc--; end
      end else begin
        if (c >= sd) begin rs = 1; if (ev != 0) nc++; else nc--; end
      end
      if (nc > 15) nc = 15;
      if (nc < 0) nc = 0;
      if (force_s) nc = 0;
      nmode = em;
      if (rs != 0 && !force_s) begin
        if (em == 0 && nc >= 12) nmode = 1;
        else if (em == 1 && nc >= 14) nmode = 2;
        else if (em == 1 && nc == 0) nmode = 0;
        else if (em == 2 && nc <= 10) nmode = 0;
      end
      if (m_frst != 0 && m_mode == 0) m_grem = 17;
      else if (m_mode != 0 && c == sd - 6) m_grem = 23;
      else if (m_grem > 0) m_grem--;
      m_seen = (rs != 0) ? 0 : ((m_seen != 0 || ev != 0) ? 1 : 0);
      m_vsq = vsync ? 1 : 0;
      m_cnt = (rs != 0) ? 1 : c + 1;
      m_mode = nmode; m_conf = nc; m_n50 = nn50; m_frst = rs;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(field_rst_o == (m_frst != 0), "R1 field restart", field_rst_o, m_frst);
      chk(mode_o == m_mode[1:0], "R5 mode", mode_o, m_mode);
      chk(id_50_o == (m_n50 != 0), "R4 norm flag", id_50_o, m_n50);
      chk(gate_o == (m_gate() != 0), "R10 gate", gate_o, m_gate());
    end
  end

  // sync stimulus, placed after the negedge so tasks settle first
  always @(negedge clk) begin
    #1;
    vsync = (tgt != 0 && m_cnt == tgt) || (tgt2 != 0 && m_cnt == tgt2);
  end

  task automatic wait_rst(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (field_rst_o) k++;
    end
  endtask

  task automatic expect_interval(input int exp, input string tag);
    int t0;
    wait_rst(1);
    t0 = cyc;
    wait_rst(1);
    chk(cyc - t0 == exp, tag, cyc - t0, exp);
  endtask

  task automatic measure_gate(input int exp, input bit srch, input string tag);
    int len = 0;
    @(negedge clk);
    while (gate_o) @(negedge clk);
    while (!gate_o) @(negedge clk);
    if (srch) chk(field_rst_o == 1'b1, "R10 search gate starts with restart", field_rst_o, 1);
    while (gate_o) begin len++; @(negedge clk); end
    chk(len == exp, tag, len, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(mode_o == 2'd0, "R11 mode in reset", mode_o, 0);
    chk(field_rst_o == 1'b0, "R11 restart in reset", field_rst_o, 0);
    chk(id_50_o == 1'b0, "R11 norm in reset", id_50_o, 0);
    chk(gate_o == 1'b0, "R11 gate in reset", gate_o, 0);
    rst_n = 1'b1;

    expect_interval(722, "R2 free-run field length");
    tgt = 400;
    expect_interval(722, "R1 edge outside search window ignored");
    tgt = 500;
    expect_interval(500, "R1 accepted edge sets field length");
    chk(mode_o == 2'd0, "R3 edge outside narrow limits does not lock", mode_o, 0);

    // lock on the 50 Hz norm
    tgt = 625;
    wait_rst(11);
    chk(mode_o == 2'd0, "R4 still searching after 11 hits", mode_o, 0);
    wait_rst(1);
    chk(mode_o == 2'd1, "R4 narrow after 12 hits", mode_o, 1);
    chk(id_50_o == 1'b1, "R4 50 Hz identified", id_50_o, 1);

    tgt = 624;
    expect_interval(624, "R5 in-window edge restarts");
    chk(mode_o == 2'd1, "R6 off-standard edge holds confidence", mode_o, 1);
    tgt = 625;
    wait_rst(1);
    chk(mode_o == 2'd1, "R6 one standard hit not enough", mode_o, 1);
    wait_rst(1);
    chk(mode_o == 2'd2, "R6 standard mode at 14", mode_o, 2);

    // standard mode: saturate, then miss down to 10
    wait_rst(1);
    chk(mode_o == 2'd2, "R3 saturating hit keeps standard", mode_o, 2);
    tgt = 600;
    expect_interval(625, "R7 fixed restart at standard count");
    wait_rst(2);
    chk(mode_o == 2'd2, "R7 still standard after 4 misses", mode_o, 2);
    wait_rst(1);
    chk(mode_o == 2'd0, "R7 search at confidence 10", mode_o, 0);

    // relock on 60 Hz from confidence 10
    tgt = 525;
    wait_rst(1);
    chk(mode_o == 2'd0, "R4 confidence 11 still search", mode_o, 0);
    wait_rst(1);
    chk(mode_o == 2'd1, "R4 narrow again", mode_o, 1);
    chk(id_50_o == 1'b0, "R4 60 Hz identified", id_50_o, 0);

    // narrow 60 Hz with missing pulses
    tgt = 0; tgt2 = 600;
    expect_interval(528, "R5 missing edge restarts at window end");
    wait_rst(9);
    chk(mode_o == 2'd1, "R5 narrow at confidence 1", mode_o, 1);
    wait_rst(1);
    chk(mode_o == 2'd0, "R5 search below 1", mode_o, 0);
    tgt2 = 0;

    // no transmitter
    notx = 1'b1;
    expect_interval(628, "R8 forced restart at 628");
    tgt = 300;
    expect_interval(722, "R8 forced restart blocked by sync");
    notx = 1'b0; tgt = 0;
    measure_gate(18, 1'b1, "R10 search gate length");

    // lock, locked gate, then force search
    tgt = 525;
    wait_rst(12);
    chk(mode_o == 2'd1, "R9 locked before force", mode_o, 1);
    measure_gate(24, 1'b0, "R10 locked gate length");
    repeat (100) @(negedge clk);
    force_s = 1'b1;
    @(negedge clk);
    force_s = 1'b0;
    chk(mode_o == 2'd0, "R9 search after force", mode_o, 0);
    wait_rst(11);
    chk(mode_o == 2'd0, "R9 confidence cleared by force", mode_o, 0);
    wait_rst(1);
    chk(mode_o == 2'd1, "R9 relock after 12 fresh hits", mode_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule